// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a guest's access to an I/O port has to leave guest execution. The host keeps a permission bitmap in memory, one bit per port. When a check is started, the block reads the two bitmap bytes that may cover the access, one byte per request. It joins them into a 16-bit window and tests every bit the access touches. An access that spans a byte boundary is therefore judged on bits from both bytes.

If any tested bit is set, the block raises an exit request. With it, the block supplies a packed qualification word and the instruction pointer captured when the check started. When checking is switched off, the check finishes at once without an exit. An access length or instruction class the block does not recognise ends in an error flag instead. The surrounding pipeline decodes the instruction, presents its port, length and class, and performs the exit itself.

Top module: `io_perm_checker`

## Requirements
- R1: After reset, `busy`, `memReqValid`, `doneValid`, `exitReq` and `errFlag` are all 0.
- R2: A start with `guestActive` or `ioInterceptEn` low issues no memory request. It pulses `doneValid` in the cycle after the start, with `exitReq` 0 and `errFlag` 0.
- R3: When checking is on, a start whose `accLen` is not 1, 2 or 4, or whose `instrClass` is 4..7, issues no memory request. It pulses `doneValid` with `errFlag` 1 and `exitReq` 0 in the cycle after the start.
- R4: A legal check reads address `bitmapBase + portNum[15:3]` first and that address plus 1 second. Each request is held, with a stable address, until a cycle with `memRspValid`, and only one is open at a time. No request is made while `busy` is 0.
- R5: The window is {second byte, first byte}. The mask is ((1<<accLen)-1) shifted left by `portNum[2:0]`. `exitReq` is 1 exactly when window AND mask is non-zero. Without an exit, `exitInfo1` and `exitInfo2` are 0.
- R6: `exitInfo1` (zero-extended to 64 bits) carries these fields: bit 0 = input access (classes 0 and 2); bit 2 = string access (classes 2 and 3); bit 3 = `repPrefix` on a string access only; bits 4, 5, 6 = length 1, 2, 4; bits 31:16 = port. All other bits are 0. Class encoding: 0 port-in, 1 port-out, 2 string-in, 3 string-out.
- R7: On an exit, `exitInfo2` equals the `instrPtr` sampled with the start.
- R8: A start raised while `busy` is 1 is ignored. It changes neither the running result nor the number of `doneValid` pulses.
- R9: For a legal check, `doneValid` pulses for one cycle in the cycle after the response to the second read is accepted plus one evaluation cycle. Its outputs are valid only with that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start a check (taken only when idle) |
| guestActive | input | 1 | Guest execution enable |
| ioInterceptEn | input | 1 | Port-access intercept enable |
| portNum | input | 16 | Port being accessed |
| accLen | input | 3 | Access length in bytes |
| instrClass | input | 3 | Instruction class code |
| repPrefix | input | 1 | Repeat prefix present |
| instrPtr | input | IP_W | Current instruction pointer |
| bitmapBase | input | ADDR_W | Bitmap base address |
| memReqValid | output | 1 | Byte read request |
| memReqAddr | output | ADDR_W | Byte read address |
| memRspValid | input | 1 | Read response strobe |
| memRspData | input | 8 | Read response byte |
| busy | output | 1 | Check in progress |
| doneValid | output | 1 | Result strobe |
| exitReq | output | 1 | Exit required |
| errFlag | output | 1 | Illegal length or class |
| exitInfo1 | output | 64 | Qualification word |
| exitInfo2 | output | IP_W | Instruction pointer on exit |

## Verification
The assertions assume the memory side asserts `memRspValid` only while a request is open. They also assume a response answers the address currently presented. The bench's responder meets this: it watches `memReqValid`, waits a chosen number of cycles, and replies for exactly one cycle with the byte at the presented address. It never replies while no request is open. Starts raised during a running check are deliberate, so the ignore rule is exercised under the same assumptions.

// File: rtl/io_perm_pkg.sv
package io_perm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD0  = 2'd1,
    ST_RD1  = 2'd2,
    ST_EVAL = 2'd3
  } stateT;

  localparam logic [2:0] CLS_PIN  = 3'd0;
  localparam logic [2:0] CLS_POUT = 3'd1;
  localparam logic [2:0] CLS_SIN  = 3'd2;
  localparam logic [2:0] CLS_SOUT = 3'd3;

  localparam int QUAL_W      = 32;
  localparam int Q_IN_BIT    = 0;
  localparam int Q_STR_BIT   = 2;
  localparam int Q_REP_BIT   = 3;
  localparam int Q_SIZE_LSB  = 4;
  localparam int Q_SIZE_CNT  = 3;
  localparam int Q_PORT_LSB  = 16;

  typedef struct packed {
    logic capture;
    logic loadLo;
    logic loadHi;
    logic finishNone;
    logic finishErr;
    logic finishEval;
  } ctrlStrobeT;

endpackage

// File: rtl/io_perm_ctrl.sv
module io_perm_ctrl
  import io_perm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic       checkOn,
  input  logic       cmdLegal,
  input  logic       memRspValid,
  output ctrlStrobeT stb,
  output logic       memReqValid,
  output logic       reqHi,
  output logic       busy
);

  stateT state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (startValid) begin
          if (!checkOn) begin
            stb.finishNone = 1'b1;
          end else if (!cmdLegal) begin
            stb.finishErr = 1'b1;
          end else begin
            stb.capture = 1'b1;
            stateNext   = ST_RD0;
          end
        end
      end
      ST_RD0: begin
        if (memRspValid) begin
          stb.loadLo = 1'b1;
          stateNext  = ST_RD1;
        end
      end
      ST_RD1: begin
        if (memRspValid) begin
          stb.loadHi = 1'b1;
          stateNext  = ST_EVAL;
        end
      end
      ST_EVAL: begin
        stb.finishEval = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign memReqValid = (state == ST_RD0) || (state == ST_RD1);
  assign reqHi       = (state == ST_RD1);
  assign busy        = (state != ST_IDLE);

endmodule

// File: rtl/io_perm_dp.sv
module io_perm_dp
  import io_perm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IP_W   = 64,
  parameter int PORT_W = 16,
  parameter int INFO_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        stb,
  input  logic              reqHi,
  input  logic [PORT_W-1:0] portNum,
  input  logic [2:0]        accLen,
  input  logic [2:0]        instrClass,
  input  logic              repPrefix,
  input  logic [IP_W-1:0]   instrPtr,
  input  logic [ADDR_W-1:0] bitmapBase,
  input  logic [7:0]        memRspData,
  output logic              cmdLegal,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              doneValid,
  output logic              exitReq,
  output logic              errFlag,
  output logic [INFO_W-1:0] exitInfo1,
  output logic [IP_W-1:0]   exitInfo2
);

  localparam int IDX_W = PORT_W - 3;
  localparam int WIN_W = 16;

  logic [PORT_W-1:0] portQ;
  logic [2:0]        lenQ;
  logic [2:0]        clsQ;
  logic              repQ;
  logic [IP_W-1:0]   ipQ;
  logic [ADDR_W-1:0] baseQ;
  logic [7:0]        loByte, hiByte;

  // Legality of the live command, used by the controller at start time.
  logic liveLenOk;
  assign liveLenOk = (accLen == 3'd1) || (accLen == 3'd2) || (accLen == 3'd4);
  assign cmdLegal  = liveLenOk && (instrClass <= CLS_SOUT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portQ  <= '0;
      lenQ   <= '0;
      clsQ   <= '0;
      repQ   <= 1'b0;
      ipQ    <= '0;
      baseQ  <= '0;
      loByte <= '0;
      hiByte <= '0;
    end else begin
      if (stb.capture) begin
        portQ <= portNum;
        lenQ  <= accLen;
        clsQ  <= instrClass;
        repQ  <= repPrefix;
        ipQ   <= instrPtr;
        baseQ <= bitmapBase;
      end
      if (stb.loadLo) loByte <= memRspData;
      if (stb.loadHi) hiByte <= memRspData;
    end
  end

  // Byte addresses of the two bitmap reads.
  logic [ADDR_W-1:0] byteIdx, loAddr;
  assign byteIdx    = {{(ADDR_W-IDX_W){1'b0}}, portQ[PORT_W-1:3]};
  assign loAddr     = baseQ + byteIdx;
  assign memReqAddr = reqHi ? (loAddr + 1'b1) : loAddr;

  // Size flags, one per supported length (1 << i bytes).
  logic [Q_SIZE_CNT-1:0] sizeFlag;
  for (genvar gi = 0; gi < Q_SIZE_CNT; gi++) begin : g_size
    assign sizeFlag[gi] = (lenQ == 3'(1 << gi));
  end

  logic [WIN_W-1:0] lenBits, mask, window;
  always_comb begin
    lenBits = '0;
    for (int k = 0; k < 4; k++) begin
      if (k < int'(lenQ)) lenBits[k] = 1'b1;
    end
  end
  assign mask   = lenBits << portQ[2:0];
  assign window = {hiByte, loByte};

  logic hit;
  assign hit = |(window & mask);

  logic isIn, isStr;
  assign isIn  = (clsQ == CLS_PIN) || (clsQ == CLS_SIN);
  assign isStr = (clsQ == CLS_SIN) || (clsQ == CLS_SOUT);

  logic [QUAL_W-1:0] qual;
  always_comb begin
    qual = '0;
    qual[Q_IN_BIT]  = isIn;
    qual[Q_STR_BIT] = isStr;
    qual[Q_REP_BIT] = isStr & repQ;
    qual[Q_SIZE_LSB +: Q_SIZE_CNT] = sizeFlag;
    qual[Q_PORT_LSB +: PORT_W]     = portQ;
  end

  logic anyFinish, takeExit;
  assign anyFinish = stb.finishNone | stb.finishErr | stb.finishEval;
  assign takeExit  = stb.finishEval & hit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      exitReq   <= 1'b0;
      errFlag   <= 1'b0;
      exitInfo1 <= '0;
      exitInfo2 <= '0;
    end else begin
      doneValid <= anyFinish;
      exitReq   <= takeExit;
      errFlag   <= stb.finishErr;
      if (anyFinish) begin
        exitInfo1 <= takeExit ? INFO_W'(qual) : '0;
        exitInfo2 <= takeExit ? ipQ : '0;
      end
    end
  end

endmodule

// File: rtl/io_perm_checker.sv
module io_perm_checker
  import io_perm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IP_W   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic              guestActive,
  input  logic              ioInterceptEn,
  input  logic [15:0]       portNum,
  input  logic [2:0]        accLen,
  input  logic [2:0]        instrClass,
  input  logic              repPrefix,
  input  logic [IP_W-1:0]   instrPtr,
  input  logic [ADDR_W-1:0] bitmapBase,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [7:0]        memRspData,
  output logic              busy,
  output logic              doneValid,
  output logic              exitReq,
  output logic              errFlag,
  output logic [63:0]       exitInfo1,
  output logic [IP_W-1:0]   exitInfo2
);

  ctrlStrobeT stb;
  logic       cmdLegal;
  logic       reqHi;
  logic       checkOn;

  assign checkOn = guestActive & ioInterceptEn;

  io_perm_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .startValid  (startValid),
    .checkOn     (checkOn),
    .cmdLegal    (cmdLegal),
    .memRspValid (memRspValid),
    .stb         (stb),
    .memReqValid (memReqValid),
    .reqHi       (reqHi),
    .busy        (busy)
  );

  io_perm_dp #(
    .ADDR_W (ADDR_W),
    .IP_W   (IP_W),
    .PORT_W (16),
    .INFO_W (64)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reqHi      (reqHi),
    .portNum    (portNum),
    .accLen     (accLen),
    .instrClass (instrClass),
    .repPrefix  (repPrefix),
    .instrPtr   (instrPtr),
    .bitmapBase (bitmapBase),
    .memRspData (memRspData),
    .cmdLegal   (cmdLegal),
    .memReqAddr (memReqAddr),
    .doneValid  (doneValid),
    .exitReq    (exitReq),
    .errFlag    (errFlag),
    .exitInfo1  (exitInfo1),
    .exitInfo2  (exitInfo2)
  );

endmodule

// File: rtl/io_perm_sva.sv
module io_perm_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic              doneValid,
  input logic              exitReq,
  input logic              errFlag,
  input logic [63:0]       exitInfo1
);

  // R1: the strobes stay low while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> !doneValid && !memReqValid);

  // R4: an open request keeps its address until answered
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRspValid) |=> (memReqValid && $stable(memReqAddr)));

  // R4: no request outside a running check
  p_req_only_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy);

  // R3: an error result never carries an exit
  p_err_no_exit_r3: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (doneValid && !exitReq));

  // R5: no exit means empty exit information
  p_no_exit_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !exitReq) |-> (exitInfo1 == 64'd0));

  // R6: exactly one size flag on an exit
  p_size_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    exitReq |-> ($countones(exitInfo1[6:4]) == 1));

  // R6: repeat only reported on a string access
  p_rep_needs_str_r6: assert property (@(posedge clk) disable iff (!rstN)
    (exitReq && !exitInfo1[2]) |-> !exitInfo1[3]);

  // R9: an exit only ever accompanies a result strobe
  p_exit_with_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    exitReq |-> doneValid);

endmodule

bind io_perm_checker io_perm_sva #(.ADDR_W(ADDR_W)) uSva (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .memReqValid (memReqValid),
  .memReqAddr  (memReqAddr),
  .memRspValid (memRspValid),
  .doneValid   (doneValid),
  .exitReq     (exitReq),
  .errFlag     (errFlag),
  .exitInfo1   (exitInfo1)
);

// File: tb/sim_io_perm_checker.sv
`timescale 1ns/1ps
module sim_io_perm_checker;

  localparam int ADDR_W = 32;
  localparam int IP_W   = 64;
  localparam logic [ADDR_W-1:0] BASE = 32'h0001_0000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startValid = 1'b0;
  logic              guestActive = 1'b0;
  logic              ioInterceptEn = 1'b0;
  logic [15:0]       portNum = '0;
  logic [2:0]        accLen = '0;
  logic [2:0]        instrClass = '0;
  logic              repPrefix = 1'b0;
  logic [IP_W-1:0]   instrPtr = '0;
  logic [ADDR_W-1:0] bitmapBase = BASE;
  logic              memReqValid;
  logic [ADDR_W-1:0] memReqAddr;
  logic              memRspValid = 1'b0;
  logic [7:0]        memRspData = '0;
  logic              busy, doneValid, exitReq, errFlag;
  logic [63:0]       exitInfo1;
  logic [IP_W-1:0]   exitInfo2;

  always #5 clk = ~clk;

  io_perm_checker #(.ADDR_W(ADDR_W), .IP_W(IP_W)) u0 (.*);

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] mem [int unsigned];
  logic [ADDR_W-1:0] reqLog [$];
  int rspDelay = 0;
  int waitCnt  = 0;
  logic [ADDR_W-1:0] expLo = '0;
  bit addrWatch = 0;

  function automatic logic [7:0] rdMem(input logic [ADDR_W-1:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory responder: answers an open request after rspDelay cycles.
  initial begin
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (memReqValid) begin
        if (waitCnt >= rspDelay) begin
          memRspValid = 1'b1;
          memRspData  = rdMem(memReqAddr);
          reqLog.push_back(memReqAddr);
          waitCnt = 0;
        end else begin
          waitCnt++;
        end
      end else begin
        waitCnt = 0;
      end
    end
  end

  // Per-cycle comparison of the request side (R4).
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && memReqValid) begin
        if (!busy || !addrWatch ||
            !(memReqAddr == expLo || memReqAddr == expLo + 1)) begin
          chk(1'b0, "R4 request outside window", 64'(memReqAddr), 64'(expLo));
        end
      end
    end
  end

  task automatic doTxn(input bit act, input bit ic, input logic [15:0] port,
                       input logic [2:0] len, input logic [2:0] cls,
                       input bit rep, input logic [63:0] ip, input int dly,
                       input bit poke, input string tag);
    int kind;
    int n;
    int expLat;
    logic [15:0] win, msk;
    bit hit;
    logic [63:0] q;
    logic [ADDR_W-1:0] lo;
    lo = BASE + ADDR_W'(port >> 3);
    if (!(act && ic)) kind = 0;
    else if (!(len == 1 || len == 2 || len == 4) || cls > 3) kind = 1;
    else kind = 2;
    win = {rdMem(lo + 1), rdMem(lo)};
    msk = 16'((1 << len) - 1) << port[2:0];
    hit = (kind == 2) && ((win & msk) != 0);
    q = 0;
    q[0] = (cls == 0 || cls == 2);
    q[2] = (cls == 2 || cls == 3);
    q[3] = q[2] & rep;
    q[4] = (len == 1);
    q[5] = (len == 2);
    q[6] = (len == 4);
    q[31:16] = port;
    expLat = (kind == 2) ? 2 * (dly + 1) + 1 : 0;

    @(negedge clk);
    reqLog.delete();
    expLo = lo;
    addrWatch = 1;
    rspDelay = dly;
    guestActive = act; ioInterceptEn = ic; portNum = port; accLen = len;
    instrClass = cls; repPrefix = rep; instrPtr = ip; startValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startValid = 1'b0;
    n = 0;
    while (!doneValid && n < 60) begin
      if (poke && n == 0) begin
        startValid = 1'b1; portNum = port ^ 16'h0808; accLen = 3'd4;
        instrClass = 3'd1; instrPtr = ~ip;
      end
      @(negedge clk);
      startValid = 1'b0;
      n++;
    end
    chk(doneValid == 1'b1, {tag, " R9 done seen"}, 64'(doneValid), 64'd1);
    chk(n == expLat, {tag, " R9 latency"}, 64'(n), 64'(expLat));
    chk(exitReq == hit, {tag, " R5 exit"}, 64'(exitReq), 64'(hit));
    chk(errFlag == (kind == 1), {tag, " R3 error"}, 64'(errFlag), 64'(kind == 1));
    chk(exitInfo1 == (hit ? q : 64'd0), {tag, " R6 qual"}, exitInfo1, hit ? q : 64'd0);
    chk(exitInfo2 == (hit ? ip : 64'd0), {tag, " R7 ip"}, exitInfo2, hit ? ip : 64'd0);
    if (kind == 2) begin
      chk(reqLog.size() == 2 && reqLog[0] == lo && reqLog[1] == lo + 1,
          {tag, " R4 read order"}, 64'(reqLog.size()), 64'd2);
    end else begin
      chk(reqLog.size() == 0, {tag, " R2 no reads"}, 64'(reqLog.size()), 64'd0);
    end
    @(negedge clk);
    chk(!doneValid && !busy, {tag, " R8 single done"}, 64'(doneValid), 64'd0);
    addrWatch = 0;
  endtask

  initial begin
    mem[BASE + 32'h000C] = 8'h01;
    mem[BASE + 32'h0021] = 8'h01;
    mem[BASE + 32'h0040] = 8'h87;
    mem[BASE + 32'h0041] = 8'h02;
    mem[BASE + 32'h1FFF] = 8'h80;
    repeat (3) @(negedge clk);
    chk(!busy && !memReqValid && !doneValid && !exitReq && !errFlag,
        "R1 reset state", 64'(busy), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    doTxn(0, 1, 16'h0060, 3'd1, 3'd0, 0, 64'h1000, 0, 0, "R2 guest off");
    doTxn(1, 0, 16'h0060, 3'd1, 3'd0, 0, 64'h1000, 0, 0, "R2 intercept off");
    doTxn(1, 1, 16'h0060, 3'd3, 3'd0, 0, 64'h1000, 0, 0, "R3 bad len");
    doTxn(1, 1, 16'h0060, 3'd1, 3'd5, 0, 64'h1000, 0, 0, "R3 bad class");
    doTxn(1, 1, 16'h0060, 3'd1, 3'd0, 0, 64'hFFFF_8000_0000_1234, 0, 0, "R5 hit in");
    doTxn(1, 1, 16'h0061, 3'd1, 3'd0, 0, 64'h2000, 1, 0, "R5 miss");
    doTxn(1, 1, 16'h0107, 3'd2, 3'd1, 0, 64'h3000, 2, 0, "R4 straddle");
    doTxn(1, 1, 16'h0206, 3'd4, 3'd3, 1, 64'h4000, 0, 0, "R6 outs rep");
    doTxn(1, 1, 16'h0060, 3'd1, 3'd1, 1, 64'h5000, 3, 0, "R6 out rep ignored");
    doTxn(1, 1, 16'hFFFF, 3'd1, 3'd2, 0, 64'h6000, 0, 0, "R4 top port");
    doTxn(1, 1, 16'h0203, 3'd4, 3'd2, 1, 64'h7000, 1, 0, "R5 mask edge");
    doTxn(1, 1, 16'h0107, 3'd2, 3'd0, 0, 64'h8000, 1, 1, "R8 busy start");
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule